// File: doc/BRIEF.md
# Core-Port Utilization Rate Monitor

This block watches the two stream ports of one processing core. The input port carries data from a statically scheduled interconnect into the core. The output port carries results from the core back to that interconnect. Each time a port attempts a transfer, it reports whether the attempt went through or was blocked. The monitor keeps a signed failure count for each direction. A blocked attempt raises the count and a successful attempt lowers it.

The two counts are read together to judge whether the core's local clock is well matched to its traffic. If the input side keeps stalling, the core is too slow. If the output side keeps stalling, the core is too fast. When one count is high and the other is low, the block issues a single-cycle request to raise or lower the frequency, then restarts both counts from zero. Two programmable thresholds separate "high" from "low", which gives hysteresis. Programmable ceiling and floor values bound both counts.

Top module: `core_rate_monitor`

## Requirements
- R1: A blocked attempt on a port (attempt high, blocked high) raises that port's count by one at the next clock edge.
- R2: A successful attempt on a port (attempt high, blocked low) lowers that port's count by one at the next clock edge.
- R3: In a cycle with no attempt on a port, that port's count is unchanged.
- R4: A blocked attempt at or above the ceiling `cnt_max_i` leaves the count equal to `cnt_max_i`. The count never wraps.
- R5: A successful attempt at or below the floor `cnt_min_i` leaves the count equal to `cnt_min_i`.
- R6: When the input count is at or above `hi_thr_i` and the output count is below `lo_thr_i`, `inc_req_o` is high for exactly the one cycle that follows.
- R7: When the output count is at or above `hi_thr_i` and the input count is below `lo_thr_i`, `dec_req_o` is high for exactly the one cycle that follows.
- R8: No request is issued in these cases: both counts are at or above `hi_thr_i`, both are below `lo_thr_i`, or either count lies between the two thresholds.
- R9: On the edge that raises a request, both counts become zero. Attempts presented in that same cycle have no effect on the counts.
- R10: After reset both counts are zero and both requests are low. `inc_req_o` and `dec_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_att_i | input | 1 | Input port transfer attempt |
| in_blk_i | input | 1 | Input port attempt was blocked (qualified by in_att_i) |
| out_att_i | input | 1 | Output port transfer attempt |
| out_blk_i | input | 1 | Output port attempt was blocked (qualified by out_att_i) |
| hi_thr_i | input | CNT_W | Signed threshold for a high count |
| lo_thr_i | input | CNT_W | Signed threshold for a low count |
| cnt_max_i | input | CNT_W | Signed ceiling for both counts |
| cnt_min_i | input | CNT_W | Signed floor for both counts |
| inc_req_o | output | 1 | One-cycle request to raise the core frequency |
| dec_req_o | output | 1 | One-cycle request to lower the core frequency |
| in_cnt_o | output | CNT_W | Signed input-side failure count |
| out_cnt_o | output | CNT_W | Signed output-side failure count |

## Verification
Two functions can act on the same clock edge. The first is the clear that follows a request. The second is the normal count update from a port attempt. To force them together, the bench brings the input count up to the high threshold. It then drives blocked attempts on both ports during the very cycle in which the request is being raised. The result is correct only if the request pulse appears and both counts read zero afterwards. The attempts made in that cycle must leave no trace.

// File: rtl/core_rate_pkg.sv
package core_rate_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned N_PORTS = 2;
  localparam int unsigned PORT_IN  = 0;
  localparam int unsigned PORT_OUT = 1;
endpackage

// File: rtl/rate_sat_counter.sv
module rate_sat_counter
  import core_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    att_i,
  input  logic                    blk_i,
  input  logic                    clr_i,
  input  logic signed [CNT_W-1:0] max_i,
  input  logic signed [CNT_W-1:0] min_i,
  output logic signed [CNT_W-1:0] cnt_o
);
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  step_e                   step;
  logic signed [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!att_i)     step = STEP_HOLD;
    else if (blk_i) step = STEP_UP;
    else            step = STEP_DOWN;
  end

  // clamp before stepping so the count never wraps
  always_comb begin
    unique case (step)
      STEP_UP:   cnt_d = (cnt_q >= max_i) ? max_i : cnt_q + ONE;
      STEP_DOWN: cnt_d = (cnt_q <= min_i) ? min_i : cnt_q - ONE;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rate_decider.sv
module rate_decider #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [CNT_W-1:0] in_cnt_i,
  input  logic signed [CNT_W-1:0] out_cnt_i,
  input  logic signed [CNT_W-1:0] hi_thr_i,
  input  logic signed [CNT_W-1:0] lo_thr_i,
  output logic                    clr_o,
  output logic                    inc_req_o,
  output logic                    dec_req_o
);
  logic in_hi, in_lo, out_hi, out_lo;
  logic inc_d, dec_d, inc_q, dec_q;

  assign in_hi  = in_cnt_i  >= hi_thr_i;
  assign in_lo  = in_cnt_i  <  lo_thr_i;
  assign out_hi = out_cnt_i >= hi_thr_i;
  assign out_lo = out_cnt_i <  lo_thr_i;

  // increase wins if thresholds are misprogrammed (hi < lo)
  assign inc_d = in_hi && out_lo;
  assign dec_d = out_hi && in_lo && !inc_d;
  assign clr_o = inc_d || dec_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      inc_q <= inc_d;
      dec_q <= dec_d;
    end
  end

  assign inc_req_o = inc_q;
  assign dec_req_o = dec_q;
endmodule

// File: rtl/core_rate_monitor.sv
module core_rate_monitor
  import core_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_att_i,
  input  logic                    in_blk_i,
  input  logic                    out_att_i,
  input  logic                    out_blk_i,
  input  logic signed [CNT_W-1:0] hi_thr_i,
  input  logic signed [CNT_W-1:0] lo_thr_i,
  input  logic signed [CNT_W-1:0] cnt_max_i,
  input  logic signed [CNT_W-1:0] cnt_min_i,
  output logic                    inc_req_o,
  output logic                    dec_req_o,
  output logic signed [CNT_W-1:0] in_cnt_o,
  output logic signed [CNT_W-1:0] out_cnt_o
);
  logic [N_PORTS-1:0]             att, blk;
  logic signed [CNT_W-1:0]        cnt [N_PORTS];
  logic                           clr;

  assign att[PORT_IN]  = in_att_i;
  assign blk[PORT_IN]  = in_blk_i;
  assign att[PORT_OUT] = out_att_i;
  assign blk[PORT_OUT] = out_blk_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    rate_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .att_i  (att[p]),
      .blk_i  (blk[p]),
      .clr_i  (clr),
      .max_i  (cnt_max_i),
      .min_i  (cnt_min_i),
      .cnt_o  (cnt[p])
    );
  end

  rate_decider #(.CNT_W(CNT_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_cnt_i  (cnt[PORT_IN]),
    .out_cnt_i (cnt[PORT_OUT]),
    .hi_thr_i  (hi_thr_i),
    .lo_thr_i  (lo_thr_i),
    .clr_o     (clr),
    .inc_req_o (inc_req_o),
    .dec_req_o (dec_req_o)
  );

  assign in_cnt_o  = cnt[PORT_IN];
  assign out_cnt_o = cnt[PORT_OUT];
endmodule

// File: rtl/core_rate_monitor_chk.sv
module core_rate_monitor_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_att_i,
  input logic                    in_blk_i,
  input logic                    out_att_i,
  input logic signed [CNT_W-1:0] hi_thr_i,
  input logic signed [CNT_W-1:0] lo_thr_i,
  input logic signed [CNT_W-1:0] cnt_max_i,
  input logic                    inc_req_o,
  input logic                    dec_req_o,
  input logic signed [CNT_W-1:0] in_cnt_o,
  input logic signed [CNT_W-1:0] out_cnt_o
);
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_req_o && dec_req_o)); // R10

  AST_CLEAR_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_req_o || dec_req_o) |-> (in_cnt_o == '0 && out_cnt_o == '0)); // R9

  AST_INC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inc_req_o) |-> ($past(in_cnt_o) >= $past(hi_thr_i)
                          && $past(out_cnt_o) < $past(lo_thr_i))); // R6

  AST_DEC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_req_o) |-> ($past(out_cnt_o) >= $past(hi_thr_i)
                          && $past(in_cnt_o) < $past(lo_thr_i))); // R7

  AST_IN_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!in_att_i) && !inc_req_o && !dec_req_o) |-> $stable(in_cnt_o)); // R3

  AST_OUT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!out_att_i) && !inc_req_o && !dec_req_o) |-> $stable(out_cnt_o)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_att_i && in_blk_i && (in_cnt_o >= cnt_max_i))
     && !inc_req_o && !dec_req_o) |-> (in_cnt_o == $past(cnt_max_i))); // R4
endmodule

bind core_rate_monitor core_rate_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_att_i  (in_att_i),
  .in_blk_i  (in_blk_i),
  .out_att_i (out_att_i),
  .hi_thr_i  (hi_thr_i),
  .lo_thr_i  (lo_thr_i),
  .cnt_max_i (cnt_max_i),
  .inc_req_o (inc_req_o),
  .dec_req_o (dec_req_o),
  .in_cnt_o  (in_cnt_o),
  .out_cnt_o (out_cnt_o)
);

// File: tb/sim_core_rate_monitor.sv
module sim_core_rate_monitor;
  localparam int unsigned CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_att_i = 1'b0, in_blk_i = 1'b0, out_att_i = 1'b0, out_blk_i = 1'b0;
  logic signed [CNT_W-1:0] hi_thr_i = 8'sd4, lo_thr_i = 8'sd2;
  logic signed [CNT_W-1:0] cnt_max_i = 8'sd6, cnt_min_i = -8'sd3;
  logic inc_req_o, dec_req_o;
  logic signed [CNT_W-1:0] in_cnt_o, out_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  core_rate_monitor #(.CNT_W(CNT_W)) u0 (
    .clk_i, .rst_ni, .in_att_i, .in_blk_i, .out_att_i, .out_blk_i,
    .hi_thr_i, .lo_thr_i, .cnt_max_i, .cnt_min_i,
    .inc_req_o, .dec_req_o, .in_cnt_o, .out_cnt_o
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle of strobes, return at the next falling edge
  task automatic cyc(logic ia, logic ib, logic oa, logic ob);
    in_att_i = ia; in_blk_i = ib; out_att_i = oa; out_blk_i = ob;
    @(negedge clk_i);
    in_att_i = 1'b0; in_blk_i = 1'b0; out_att_i = 1'b0; out_blk_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "reset in_cnt", int'(in_cnt_o), 0);
    chk("R10", "reset out_cnt", int'(out_cnt_o), 0);
    chk("R10", "reset inc", int'(inc_req_o), 0);
    chk("R10", "reset dec", int'(dec_req_o), 0);
  endtask

  task automatic t_count();
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0);
    chk("R1", "in_cnt after 3 blocked", int'(in_cnt_o), 3);
    cyc(0, 0, 1, 1);
    chk("R1", "out_cnt after 1 blocked", int'(out_cnt_o), 1);
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0);
    chk("R2", "in_cnt after 2 success", int'(in_cnt_o), 1);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1);
    chk("R3", "in_cnt idle", int'(in_cnt_o), 1);
    chk("R3", "out_cnt idle", int'(out_cnt_o), 1);
    chk("R8", "no req when both low", int'(inc_req_o | dec_req_o), 0);
  endtask

  task automatic t_saturate();
    hi_thr_i = 8'sd100; lo_thr_i = -8'sd100;
    do_reset();
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0);
    chk("R4", "in_cnt at ceiling", int'(in_cnt_o), 6);
    for (int i = 0; i < 12; i++) cyc(1, 0, 1, 0);
    chk("R5", "in_cnt at floor", int'(in_cnt_o), -3);
    chk("R5", "out_cnt at floor", int'(out_cnt_o), -3);
    hi_thr_i = 8'sd4; lo_thr_i = 8'sd2;
  endtask

  task automatic t_inc();
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);
    chk("R6", "in_cnt reaches high", int'(in_cnt_o), 4);
    chk("R6", "no req yet", int'(inc_req_o), 0);
    cyc(0, 0, 0, 0);
    chk("R6", "inc pulse", int'(inc_req_o), 1);
    chk("R10", "dec low with inc", int'(dec_req_o), 0);
    chk("R9", "in_cnt cleared", int'(in_cnt_o), 0);
    cyc(0, 0, 0, 0);
    chk("R6", "inc single cycle", int'(inc_req_o), 0);
  endtask

  task automatic t_dec();
    do_reset();
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    chk("R7", "dec pulse", int'(dec_req_o), 1);
    chk("R10", "inc low with dec", int'(inc_req_o), 0);
    chk("R9", "out_cnt cleared", int'(out_cnt_o), 0);
    cyc(0, 0, 0, 0);
    chk("R7", "dec single cycle", int'(dec_req_o), 0);
  endtask

  task automatic t_hold();
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R8", "both high no req", int'(inc_req_o | dec_req_o), 0);
    chk("R8", "both high kept", int'(in_cnt_o) + int'(out_cnt_o), 8);
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R8", "out between thresholds no req", int'(inc_req_o | dec_req_o), 0);
    chk("R8", "out_cnt between", int'(out_cnt_o), 3);
  endtask

  task automatic t_clear_race();
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);
    cyc(1, 1, 1, 1);
    chk("R9", "inc during race", int'(inc_req_o), 1);
    chk("R9", "in_cnt zero despite attempt", int'(in_cnt_o), 0);
    chk("R9", "out_cnt zero despite attempt", int'(out_cnt_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_count();
    t_saturate();
    t_inc();
    t_dec();
    t_hold();
    t_clear_race();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule